// File: doc/BRIEF.md
# Single and Double Length Barrel Shifter

This block is the shift unit of a word-oriented datapath. It takes a 36-bit word, or a pair of words joined into one 72-bit value, and applies one of six operations. The operations are right and left circular rotation, right and left logical shifts, an arithmetic right shift that copies the sign bit, and a normalizing left shift. The normalizing shift slides the operand left until its top two bits differ and returns the number of places it moved.

The shift amount is a 7-bit count, nominally 0 to 72. Every operation has the same latency whatever the count. The inputs are sampled on a rising clock edge, and the result and the normalize count are held in output registers until the next edge. A length select picks the single-word or double-word form.

Top module: `barrel_shifter`

## Requirements
- R1: While rst_n is low at a rising edge, res_hi, res_lo and norm_cnt are all zero after that edge.
- R2: The result and count for inputs present at a rising edge appear after that edge and hold until the next one. The latency is the same for every count from 0 to 127 and for every operation.
- R3: With dbl_len = 0, the operand is opnd_lo alone and the result is in res_lo. In this mode res_hi is zero and opnd_hi has no effect on any output.
- R4: With dbl_len = 1, the operand is the 72-bit value {opnd_hi, opnd_lo}, with opnd_hi as the upper half. The result is returned the same way in {res_hi, res_lo}.
- R5: Operation code 0 rotates right and code 3 rotates left. The bits shifted out re-enter at the opposite end, and the count is taken modulo the operand width (36 or 72).
- R6: Operation code 1 is a logical right shift and code 4 is a logical left shift. Zeros enter at the end opposite the shift direction, and a count equal to or greater than the width gives all zeros.
- R7: Operation code 2 is an arithmetic right shift. Copies of the operand's top bit enter from the left, and a count equal to or greater than the width gives a word filled with the sign bit.
- R8: Operation code 5 shifts the operand left with zero fill until bit width-1 differs from bit width-2. The number of places moved is placed on norm_cnt, and shamt has no effect.
- R9: For operation code 5, an operand that is all zeros or all ones is shifted by width-1 places, and norm_cnt reports width-1 (35 or 71).
- R10: Operation codes 6 and 7 return the operand unchanged. For every code other than 5, norm_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 3 | Operation select (see R5 to R10) |
| dbl_len | input | 1 | 1 selects the 72-bit operand pair, 0 selects the single 36-bit word |
| shamt | input | 7 | Shift count |
| opnd_hi | input | 36 | Upper operand word, used only in double length |
| opnd_lo | input | 36 | Lower operand word, or the whole operand in single length |
| res_hi | output | 36 | Upper result word, zero in single length |
| res_lo | output | 36 | Lower result word |
| norm_cnt | output | 7 | Places moved by the normalizing shift |

## Verification
Random operands are run with counts drawn from the full 7-bit range and weighted toward 0, 1, width-1, width, width+1 and 127. These counts separate the modulo rule of the rotations from the saturation rule of the logical and arithmetic shifts, and they expose off-by-one errors at each width. Operands with a negative sign show whether a right shift copies the sign bit or fills with zeros. Single-length cases with random data in the unused upper word show whether that word can leak into the result. Normalize cases use zero, all-ones, already-normalized and long-sign-run operands, which tell apart the stop condition, the width-1 limit and a count that is off by one place.

// File: rtl/barrel_pkg.sv
// Package: shared operation encoding for the barrel shifter.
// Assumes a 3-bit operation field driven by the datapath decoder.
package barrel_pkg;

    typedef enum logic [2:0] {
        OP_ROTR = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASR  = 3'd2,
        OP_ROTL = 3'd3,
        OP_LSL  = 3'd4,
        OP_NORM = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shift_op_e;

endpackage

// File: rtl/barrel_shift_core.sv
// Module: barrel_shift_core
// Combinational rotate / logical / arithmetic shifter for one operand width.
// Assumes AMT_W bits are enough to hold W. Rotations take the count modulo W.
// Non-circular shifts saturate at W. Codes without a shift pass the operand through.
module barrel_shift_core
    import barrel_pkg::*;
#(
    parameter int W     = 36,
    parameter int AMT_W = 7
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  shift_op_e        op,
    output logic [W-1:0]     dout
);

    logic [AMT_W-1:0] rot_r;
    logic [AMT_W-1:0] rot_l;
    logic             sat;
    logic [2*W-1:0]   twin;
    logic [2*W-1:0]   sext;

    // Reduce the count: modulo for rotation, saturation flag for plain shifts
    always_comb begin
        rot_r = AMT_W'(amt % AMT_W'(W));
        rot_l = (rot_r == '0) ? '0 : AMT_W'(AMT_W'(W) - rot_r);
        sat   = (amt >= AMT_W'(W));
        twin  = {din, din};
        sext  = {{W{din[W-1]}}, din};
    end

    // Select the shifted value for the requested operation
    always_comb begin
        case (op)
            OP_ROTR: dout = W'(twin >> rot_r);
            OP_ROTL: dout = W'(twin >> rot_l);
            OP_LSR:  dout = sat ? '0 : (din >> amt);
            OP_LSL:  dout = sat ? '0 : (din << amt);
            OP_ASR:  dout = sat ? {W{din[W-1]}} : W'(sext >> amt);
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/barrel_norm.sv
// Module: barrel_norm
// Combinational normalizer. It counts the leading copies of the sign bit beyond
// the first and shifts them out to the left.
// Assumes W >= 2. A uniform operand gives a count of W-1.
module barrel_norm #(
    parameter int W     = 36,
    parameter int AMT_W = 7
) (
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [AMT_W-1:0] cnt
);

    logic found;

    // Scan from the top for the first bit that differs from the sign bit
    always_comb begin
        cnt   = AMT_W'(W - 1);
        found = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!found && (din[i] != din[W-1])) begin
                cnt   = AMT_W'(W - 2 - i);
                found = 1'b1;
            end
        end
        dout = din << cnt;
    end

    // A non-uniform operand must end up with its top two bits different
    always_comb begin
        if (!$isunknown(din) && found) begin
            assert_norm_top_R8: assert (dout[W-1] != dout[W-2])
                else $error("normalized top bits equal");
        end
    end

endmodule

// File: rtl/barrel_shifter.sv
// Module: barrel_shifter (top)
// One-cycle shift unit for single (WORD_W) or double (2*WORD_W) operands.
// Holds one single-width and one double-width shifter and normalizer, selects
// by length and operation, and registers the result.
// Assumes the inputs are stable around the rising clock edge.
module barrel_shifter
    import barrel_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2:0]                        op_code,
    input  logic                              dbl_len,
    input  logic [$clog2(2*WORD_W+1)-1:0]     shamt,
    input  logic [WORD_W-1:0]                 opnd_hi,
    input  logic [WORD_W-1:0]                 opnd_lo,
    output logic [WORD_W-1:0]                 res_hi,
    output logic [WORD_W-1:0]                 res_lo,
    output logic [$clog2(2*WORD_W+1)-1:0]     norm_cnt
);

    localparam int DBL_W = 2 * WORD_W;
    localparam int CNT_W = $clog2(DBL_W + 1);

    shift_op_e          op;
    logic [WORD_W-1:0]  s_shift, s_norm;
    logic [DBL_W-1:0]   d_shift, d_norm;
    logic [CNT_W-1:0]   s_cnt, d_cnt;
    logic [DBL_W-1:0]   next_res;
    logic [CNT_W-1:0]   next_cnt;

    assign op = shift_op_e'(op_code);

    barrel_shift_core #(.W(WORD_W), .AMT_W(CNT_W)) u_core_sgl (
        .din(opnd_lo), .amt(shamt), .op(op), .dout(s_shift));

    barrel_shift_core #(.W(DBL_W), .AMT_W(CNT_W)) u_core_dbl (
        .din({opnd_hi, opnd_lo}), .amt(shamt), .op(op), .dout(d_shift));

    barrel_norm #(.W(WORD_W), .AMT_W(CNT_W)) u_norm_sgl (
        .din(opnd_lo), .dout(s_norm), .cnt(s_cnt));

    barrel_norm #(.W(DBL_W), .AMT_W(CNT_W)) u_norm_dbl (
        .din({opnd_hi, opnd_lo}), .dout(d_norm), .cnt(d_cnt));

    // Pick the result path by length and operation
    always_comb begin
        if (op == OP_NORM) begin
            next_res = dbl_len ? d_norm : {{WORD_W{1'b0}}, s_norm};
            next_cnt = dbl_len ? d_cnt  : s_cnt;
        end else begin
            next_res = dbl_len ? d_shift : {{WORD_W{1'b0}}, s_shift};
            next_cnt = '0;
        end
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi   <= '0;
            res_lo   <= '0;
            norm_cnt <= '0;
        end else begin
            res_hi   <= next_res[DBL_W-1:WORD_W];
            res_lo   <= next_res[WORD_W-1:0];
            norm_cnt <= next_cnt;
        end
    end

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (res_hi == '0 && res_lo == '0 && norm_cnt == '0))
        else $error("outputs not cleared by reset");

    assert_single_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_len) |=> (res_hi == '0))
        else $error("upper result nonzero in single length");

    assert_rotate_keeps_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_len && (op_code == 3'd0 || op_code == 3'd3))
        |=> ($countones({res_hi, res_lo}) == $countones($past({opnd_hi, opnd_lo}))))
        else $error("rotation changed the number of ones");

    assert_logical_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_len && (op_code == 3'd1 || op_code == 3'd4) && shamt >= CNT_W'(DBL_W))
        |=> (res_hi == '0 && res_lo == '0))
        else $error("saturated logical shift not zero");

    assert_asr_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_len && op_code == 3'd2) |=> (res_hi[WORD_W-1] == $past(opnd_hi[WORD_W-1])))
        else $error("arithmetic shift lost the sign");

    assert_cnt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 3'd5) |=> (norm_cnt == '0))
        else $error("normalize count nonzero for other operation");

endmodule

// File: tb/barrel_shifter_bench.sv
module barrel_shifter_bench;

    localparam int WW = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = '0;
    logic        dbl_len = 1'b0;
    logic [6:0]  shamt = '0;
    logic [35:0] opnd_hi = '0;
    logic [35:0] opnd_lo = '0;
    logic [35:0] res_hi, res_lo;
    logic [6:0]  norm_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    logic [71:0] last_res = '0;
    logic [6:0]  last_cnt = '0;

    always #2.5 clk = ~clk;

    barrel_shifter #(.WORD_W(WW)) u_barrel_shifter (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .dbl_len(dbl_len),
        .shamt(shamt), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
        .res_hi(res_hi), .res_lo(res_lo), .norm_cnt(norm_cnt));

    // Reference model: one bit step at a time, from the requirements
    function automatic void ref_model(input logic [2:0] op, input logic dbl,
                                      input int amt, input logic [71:0] vin,
                                      output logic [71:0] r, output int c);
        int w = dbl ? 72 : 36;
        logic [71:0] mask = dbl ? {72{1'b1}} : {36'd0, {36{1'b1}}};
        logic [71:0] top  = 72'd1 << (w - 1);
        logic [71:0] v    = vin & mask;
        logic s;
        c = 0;
        case (op)
            3'd0: repeat (amt % w) v = (v >> 1) | (v[0] ? top : 72'd0);
            3'd1: repeat (amt) v = v >> 1;
            3'd2: begin s = v[w-1]; repeat (amt) v = (v >> 1) | (s ? top : 72'd0); end
            3'd3: repeat (amt % w) begin s = v[w-1]; v = ((v << 1) & mask) | {71'd0, s}; end
            3'd4: repeat (amt) v = (v << 1) & mask;
            3'd5: while (c < w - 1 && v[w-1] == v[w-2]) begin v = (v << 1) & mask; c++; end
            default: ;
        endcase
        r = v;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd3: return "R5";
            3'd1, 3'd4: return "R6";
            3'd2:       return "R7";
            3'd5:       return "R8";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp,
                         input logic [6:0] acnt, input logic [6:0] ecnt);
        n_tests++;
        if (act !== exp || acnt !== ecnt) begin
            n_fail++;
            $display("FAIL %s: actual res=%h cnt=%0d expected res=%h cnt=%0d",
                     req, act, acnt, exp, ecnt);
        end
    endtask

    // Drive at a falling edge, confirm the old result holds (R2), sample after the next rise
    task automatic apply(input logic [2:0] op, input logic dbl, input logic [6:0] amt,
                         input logic [35:0] hi, input logic [35:0] lo, input string req);
        logic [71:0] er;
        int ec;
        op_code = op; dbl_len = dbl; shamt = amt; opnd_hi = hi; opnd_lo = lo;
        ref_model(op, dbl, int'(amt), dbl ? {hi, lo} : {36'd0, lo}, er, ec);
        #1;
        check("R2 hold", {res_hi, res_lo}, last_res, norm_cnt, last_cnt);
        @(posedge clk);
        @(negedge clk);
        check(req, {res_hi, res_lo}, er, norm_cnt, 7'(ec));
        last_res = er;
        last_cnt = 7'(ec);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] picks [10];
        void'($urandom(32'd4711));
        picks = '{7'd0, 7'd1, 7'd35, 7'd36, 7'd37, 7'd71, 7'd72, 7'd73, 7'd127, 7'd2};
        opnd_hi = 36'hFFF_FFFF_FF; opnd_lo = 36'h1234_5678_9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {res_hi, res_lo}, 72'd0, norm_cnt, 7'd0);
        rst_n = 1'b1;

        // Directed corner cases
        apply(3'd0, 1'b0, 7'd4, 36'hABC_DEF0_12, 36'h0_0000_000F, "R5 R3 rotr single");
        apply(3'd3, 1'b1, 7'd76, 36'h8_0000_0000, 36'h0_0000_0001, "R5 R4 rotl mod 72");
        apply(3'd0, 1'b0, 7'd36, 36'h0, 36'h5_A5A5_A5A5, "R5 rotr by width");
        apply(3'd1, 1'b1, 7'd72, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, "R6 lsr sat");
        apply(3'd4, 1'b0, 7'd35, 36'hF_FFFF_FFFF, 36'h0_0000_0003, "R6 R3 lsl 35");
        apply(3'd2, 1'b1, 7'd40, 36'h8_0000_0000, 36'h0, "R7 R4 asr double");
        apply(3'd2, 1'b0, 7'd100, 36'h0, 36'h8_0000_0001, "R7 asr sat");
        apply(3'd5, 1'b0, 7'd9, 36'hF_FFFF_FFFF, 36'h0, "R9 norm zero single");
        apply(3'd5, 1'b1, 7'd0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, "R9 norm ones double");
        apply(3'd5, 1'b1, 7'd3, 36'h0, 36'h0_0000_0001, "R8 norm long run");
        apply(3'd5, 1'b0, 7'd50, 36'h0, 36'h4_0000_0000, "R8 norm already");
        apply(3'd6, 1'b1, 7'd5, 36'h1_2345_6789, 36'hA_BCDE_F012, "R10 pass");
        apply(3'd7, 1'b0, 7'd5, 36'h1_2345_6789, 36'hA_BCDE_F012, "R10 R3 pass single");

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic [2:0]  op  = 3'($urandom % 8);
            logic        dbl = 1'($urandom % 2);
            logic [6:0]  amt = ($urandom % 2 == 0) ? 7'($urandom % 128) : picks[$urandom % 10];
            logic [35:0] hi  = 36'({$urandom, $urandom});
            logic [35:0] lo  = 36'({$urandom, $urandom});
            if (op == 3'd5 && ($urandom % 2 == 1)) begin
                logic [71:0] v = {hi, lo} >> ($urandom % 72);
                if ($urandom % 2 == 1) v = ~v;
                {hi, lo} = v;
            end
            apply(op, dbl, amt, hi, lo, {tag_of(op), dbl ? " R4" : " R3"});
        end

        // Reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset again", {res_hi, res_lo}, 72'd0, norm_cnt, 7'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule